// File: doc/BRIEF.md
# Receive Packet Status Queue

This block keeps track of the packets that sit in a receive byte buffer and shows a 16-bit status word for the oldest one. The MAC side announces a packet start, then sends one strobe per stored byte, then an end strobe with a 4-bit error code. The host side pulls bytes one at a time from the oldest packet. It can drop that packet with a discard command, or empty everything with a receive-reset command. The byte storage itself lives elsewhere. This block only counts the bytes: how many each queued packet holds, and how many the buffer holds in total.

Alongside the status word the block raises several flags. One shows a packet being written. One shows that the byte buffer has filled. One shows that the packet queue is full. One shows that the host read past the data it has, which also raises an adapter-failure cause. A receive-complete cause tells the host that the oldest entry is a finished packet.

Top module: `rx_status_queue`

## Requirements
- R1: The status word puts an incomplete/empty flag in bit 15 and a byte count (0..1514) in bits 10..0. Bit 15 is 1 when the queue is empty or the oldest packet is still being received. An empty queue reads exactly 0x8000. A packet still being received shows error code 0 and the bytes counted so far.
- R2: At the end of a packet, the 4-bit error code given by the MAC is stored as-is. It is shown in bits 14..11 once that packet is the oldest. Codes with bit 14 set mark errors: 1000 overrun, 1001 oversize, 1011 runt, 1100 alignment, 1101 CRC. Code 0010 marks dribble bits. Every other code passes through unchanged.
- R3: A packet keeps at most 1514 bytes; further bytes are dropped. A packet that lost bytes this way finishes with code 1001, unless R5 applies.
- R4: The queue holds at most 8 packets. While 8 are queued, the status-overrun flag is high and a packet start is refused, along with all of that packet's bytes and its end. The flag drops as soon as a packet is removed.
- R5: The RX-overrun flag rises one cycle after the buffer holds BUF_BYTES (2048) bytes. It falls one cycle after occupancy falls to BUF_BYTES-OVR_HYST (2044) or below. A byte that arrives while the buffer is full is dropped, and its packet finishes with code 1000. A packet start is refused while the flag is high.
- R6: A host read while the queue is empty, or with no unread byte left in the oldest packet, sets the RX-underrun flag and the adapter-failure cause from the next cycle on. Both stay high until receive reset or global reset.
- R7: The command word carries its opcode in bits 15..11. Opcode 8 (discard) removes the oldest packet if it is complete, frees its unread bytes and moves the next packet to the top. A discard has no effect on an empty queue or on a packet still being received.
- R8: Opcode 5 (receive reset) empties the queue and clears every flag. It also abandons a packet in progress, so the rest of that packet's bytes and its end are ignored.
- R9: The receiving flag is high from the cycle after an accepted start until the cycle after its end.
- R10: The RX-complete cause is high exactly when the oldest entry is a finished packet.
- R11: Packets are presented oldest first.
- R12: After global reset the status word is 0x8000 and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low global reset |
| macStart | input | 1 | A new packet begins |
| macByte | input | 1 | One byte of the current packet was stored |
| macEnd | input | 1 | Current packet ends |
| macErr | input | 4 | Error code given with macEnd |
| hostRead | input | 1 | Host reads one byte of the oldest packet |
| cmdValid | input | 1 | Command word is valid this cycle |
| cmdWord | input | 16 | Command, opcode in bits 15..11 |
| statusWord | output | 16 | Status of the oldest packet |
| rxComplete | output | 1 | Oldest entry is a finished packet |
| rxReceiving | output | 1 | A packet is being written |
| rxOverrun | output | 1 | Byte buffer full (with hysteresis) |
| statusOverrun | output | 1 | Packet queue full |
| rxUnderrun | output | 1 | Host read past the data of the oldest packet |
| adapterFail | output | 1 | Adapter-failure cause |

## Verification
Some rules are checked by assertions on every cycle:
- the queue never takes a ninth packet, and no start is accepted while the overrun flag is up;
- a discard only ever pops a finished packet;
- the stored length never exceeds 1514;
- host reads stay inside the received data;
- the underrun flag stays high until a reset;
- receive reset empties the counts.

The bench scenarios are needed for the rest. These are the exact status values per error code, the oldest-first order, the 2048/2044 hysteresis points and their timing, and the way a refused or abandoned packet vanishes completely from the status word.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int LEN_W = 11;
  localparam int ERR_W = 4;

  localparam logic [4:0] OP_RX_RESET = 5'd5;
  localparam logic [4:0] OP_DISCARD  = 5'd8;

  localparam logic [ERR_W-1:0] CODE_OVERRUN  = 4'b1000;
  localparam logic [ERR_W-1:0] CODE_OVERSIZE = 4'b1001;

  // One queued packet
  typedef struct packed {
    logic             done;
    logic [ERR_W-1:0] err;
    logic [LEN_W-1:0] len;
  } rxqEntry_t;

  // Control to datapath strobes
  typedef struct packed {
    logic             push;
    logic             byteIn;
    logic             endPkt;
    logic [ERR_W-1:0] endErr;
    logic             byteOut;
    logic             pop;
    logic             clear;
  } rxqStrobe_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int MAX_PKTS  = 8,
  parameter int BUF_BYTES = 2048,
  parameter int MAX_LEN   = 1514,
  parameter int OVR_HYST  = 4,
  localparam int CNT_W = $clog2(MAX_PKTS + 1),
  localparam int BUF_W = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             macStart,
  input  logic             macByte,
  input  logic             macEnd,
  input  logic [ERR_W-1:0] macErr,
  input  logic             hostRead,
  input  logic             cmdValid,
  input  logic [15:0]      cmdWord,
  input  logic [CNT_W-1:0] pktCount,
  input  logic [BUF_W-1:0] bufUsed,
  input  logic [LEN_W-1:0] curLen,
  input  logic             topDone,
  input  logic [LEN_W-1:0] topLen,
  input  logic [LEN_W-1:0] readIdx,
  output rxqStrobe_t       strobe,
  output logic             receiving,
  output logic             rxOverrun,
  output logic             rxUnderrun
);
  localparam logic [BUF_W-1:0] FULL_LVL  = BUF_W'(BUF_BYTES);
  localparam logic [BUF_W-1:0] CLEAR_LVL = BUF_W'(BUF_BYTES - OVR_HYST);
  localparam logic [LEN_W-1:0] LEN_CAP   = LEN_W'(MAX_LEN);
  localparam logic [CNT_W-1:0] CNT_CAP   = CNT_W'(MAX_PKTS);

  logic lostBytes, tooLong;
  logic isClear, isDiscard, queueEmpty, bufFull;
  logic dropFull, dropLong, readBad;

  always_comb begin
    isClear    = cmdValid && (cmdWord[15:11] == OP_RX_RESET);
    isDiscard  = cmdValid && (cmdWord[15:11] == OP_DISCARD);
    queueEmpty = (pktCount == '0);
    bufFull    = (bufUsed >= FULL_LVL);
    strobe     = '0;
    dropFull   = 1'b0;
    dropLong   = 1'b0;
    readBad    = 1'b0;
    if (isClear) begin
      strobe.clear = 1'b1;
    end else begin
      strobe.pop     = isDiscard && !queueEmpty && topDone;
      strobe.push    = macStart && !receiving && !rxOverrun && (pktCount < CNT_CAP);
      dropFull       = macByte && receiving && bufFull;
      dropLong       = macByte && receiving && !bufFull && (curLen >= LEN_CAP);
      strobe.byteIn  = macByte && receiving && !bufFull && (curLen < LEN_CAP);
      strobe.endPkt  = macEnd && receiving;
      if (lostBytes || dropFull)      strobe.endErr = CODE_OVERRUN;
      else if (tooLong || dropLong)   strobe.endErr = CODE_OVERSIZE;
      else                            strobe.endErr = macErr;
      readBad        = hostRead && !strobe.pop && (queueEmpty || (readIdx >= topLen));
      strobe.byteOut = hostRead && !strobe.pop && !readBad;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      receiving  <= 1'b0;
      lostBytes  <= 1'b0;
      tooLong    <= 1'b0;
      rxOverrun  <= 1'b0;
      rxUnderrun <= 1'b0;
    end else if (strobe.clear) begin
      receiving  <= 1'b0;
      lostBytes  <= 1'b0;
      tooLong    <= 1'b0;
      rxOverrun  <= 1'b0;
      rxUnderrun <= 1'b0;
    end else begin
      if (strobe.push) begin
        receiving <= 1'b1;
        lostBytes <= 1'b0;
        tooLong   <= 1'b0;
      end else begin
        if (strobe.endPkt) receiving <= 1'b0;
        if (dropFull)      lostBytes <= 1'b1;
        if (dropLong)      tooLong   <= 1'b1;
      end
      if (readBad) rxUnderrun <= 1'b1;
      if (bufFull)                     rxOverrun <= 1'b1;
      else if (bufUsed <= CLEAR_LVL)   rxOverrun <= 1'b0;
    end
  end

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    rxUnderrun && !strobe.clear |=> rxUnderrun); // R6
  AST_NO_START_IN_OVR: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |-> !strobe.push); // R5
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rstN)
    curLen <= LEN_CAP); // R3
  AST_RECV_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.endPkt |=> !receiving); // R9
endmodule

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int MAX_PKTS  = 8,
  parameter int BUF_BYTES = 2048,
  localparam int PTR_W = (MAX_PKTS > 1) ? $clog2(MAX_PKTS) : 1,
  localparam int CNT_W = $clog2(MAX_PKTS + 1),
  localparam int BUF_W = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxqStrobe_t       strobe,
  output logic [CNT_W-1:0] pktCount,
  output logic [BUF_W-1:0] bufUsed,
  output logic [LEN_W-1:0] curLen,
  output logic             topDone,
  output logic [LEN_W-1:0] topLen,
  output logic [LEN_W-1:0] readIdx,
  output logic [15:0]      statusWord,
  output logic             rxComplete,
  output logic             statusOverrun
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(MAX_PKTS - 1);
  localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(MAX_PKTS);

  rxqEntry_t        entries [MAX_PKTS];
  rxqEntry_t        topEntry;
  logic [PTR_W-1:0] headPtr, tailPtr, curPtr;
  logic [BUF_W-1:0] freed;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    topEntry = entries[headPtr];
    topDone  = topEntry.done;
    topLen   = topEntry.len;
    curLen   = entries[curPtr].len;
    freed    = strobe.pop ? BUF_W'(topEntry.len - readIdx) : '0;
    if (pktCount == '0)
      statusWord = 16'h8000;
    else if (!topEntry.done)
      statusWord = {1'b1, 4'b0000, topEntry.len};
    else
      statusWord = {1'b0, topEntry.err, topEntry.len};
    rxComplete    = (pktCount != '0) && topEntry.done;
    statusOverrun = (pktCount == CNT_CAP);
  end

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.clear) begin
      entries[tailPtr] <= '0;
    end else if (!strobe.clear) begin
      if (strobe.byteIn) entries[curPtr].len <= entries[curPtr].len + 1'b1;
      if (strobe.endPkt) begin
        entries[curPtr].done <= 1'b1;
        entries[curPtr].err  <= strobe.endErr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      curPtr   <= '0;
      pktCount <= '0;
      bufUsed  <= '0;
      readIdx  <= '0;
    end else if (strobe.clear) begin
      headPtr  <= '0;
      tailPtr  <= '0;
      curPtr   <= '0;
      pktCount <= '0;
      bufUsed  <= '0;
      readIdx  <= '0;
    end else begin
      if (strobe.push) begin
        curPtr  <= tailPtr;
        tailPtr <= nextPtr(tailPtr);
      end
      if (strobe.pop) begin
        headPtr <= nextPtr(headPtr);
        readIdx <= '0;
      end else if (strobe.byteOut) begin
        readIdx <= readIdx + 1'b1;
      end
      pktCount <= pktCount + CNT_W'(strobe.push) - CNT_W'(strobe.pop);
      bufUsed  <= bufUsed + BUF_W'(strobe.byteIn) - BUF_W'(strobe.byteOut) - freed;
    end
  end

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> pktCount < CNT_CAP); // R4
  AST_POP_FINISHED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (pktCount != '0) && topEntry.done); // R7
  AST_READ_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.byteOut |-> readIdx < topEntry.len); // R6
  AST_BUF_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bufUsed <= BUF_W'(BUF_BYTES)); // R5
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (pktCount == '0) && (bufUsed == '0)); // R8
endmodule

// File: rtl/rx_status_queue.sv
module rx_status_queue
  import rxq_pkg::*;
#(
  parameter int MAX_PKTS  = 8,
  parameter int BUF_BYTES = 2048,
  parameter int MAX_LEN   = 1514,
  parameter int OVR_HYST  = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        macStart,
  input  logic        macByte,
  input  logic        macEnd,
  input  logic [3:0]  macErr,
  input  logic        hostRead,
  input  logic        cmdValid,
  input  logic [15:0] cmdWord,
  output logic [15:0] statusWord,
  output logic        rxComplete,
  output logic        rxReceiving,
  output logic        rxOverrun,
  output logic        statusOverrun,
  output logic        rxUnderrun,
  output logic        adapterFail
);
  localparam int CNT_W = $clog2(MAX_PKTS + 1);
  localparam int BUF_W = $clog2(BUF_BYTES + 1);

  rxqStrobe_t       strobe;
  logic [CNT_W-1:0] pktCount;
  logic [BUF_W-1:0] bufUsed;
  logic [LEN_W-1:0] curLen, topLen, readIdx;
  logic             topDone;

  rxq_ctrl #(
    .MAX_PKTS(MAX_PKTS), .BUF_BYTES(BUF_BYTES), .MAX_LEN(MAX_LEN), .OVR_HYST(OVR_HYST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .macStart(macStart), .macByte(macByte), .macEnd(macEnd), .macErr(macErr),
    .hostRead(hostRead), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .pktCount(pktCount), .bufUsed(bufUsed), .curLen(curLen),
    .topDone(topDone), .topLen(topLen), .readIdx(readIdx),
    .strobe(strobe), .receiving(rxReceiving),
    .rxOverrun(rxOverrun), .rxUnderrun(rxUnderrun)
  );

  rxq_datapath #(
    .MAX_PKTS(MAX_PKTS), .BUF_BYTES(BUF_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pktCount(pktCount), .bufUsed(bufUsed), .curLen(curLen),
    .topDone(topDone), .topLen(topLen), .readIdx(readIdx),
    .statusWord(statusWord), .rxComplete(rxComplete),
    .statusOverrun(statusOverrun)
  );

  assign adapterFail = rxUnderrun;
endmodule

// File: tb/rx_status_queue_tb.sv
module rx_status_queue_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        macStart = 1'b0, macByte = 1'b0, macEnd = 1'b0;
  logic [3:0]  macErr = 4'd0;
  logic        hostRead = 1'b0, cmdValid = 1'b0;
  logic [15:0] cmdWord = 16'd0;
  logic [15:0] statusWord;
  logic        rxComplete, rxReceiving, rxOverrun, statusOverrun, rxUnderrun, adapterFail;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_status_queue u_dut (
    .clk(clk), .rstN(rstN), .macStart(macStart), .macByte(macByte), .macEnd(macEnd),
    .macErr(macErr), .hostRead(hostRead), .cmdValid(cmdValid), .cmdWord(cmdWord),
    .statusWord(statusWord), .rxComplete(rxComplete), .rxReceiving(rxReceiving),
    .rxOverrun(rxOverrun), .statusOverrun(statusOverrun), .rxUnderrun(rxUnderrun),
    .adapterFail(adapterFail)
  );

  // {expected status[31:16], error code[15:12], 0, length[10:0]}
  localparam logic [31:0] VEC [7] = '{
    32'h003C_003C, 32'h6840_D040, 32'h5800_B000, 32'h15EA_25EA,
    32'h6064_C064, 32'h4801_9001, 32'h3807_7007
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic startPkt();
    macStart = 1'b1; tick(); macStart = 1'b0;
  endtask

  task automatic sendBytes(input int n);
    for (int i = 0; i < n; i++) begin
      macByte = 1'b1; tick();
    end
    macByte = 1'b0;
  endtask

  task automatic endPkt(input logic [3:0] code);
    macEnd = 1'b1; macErr = code; tick(); macEnd = 1'b0; macErr = 4'd0;
  endtask

  task automatic sendPkt(input int n, input logic [3:0] code);
    startPkt(); sendBytes(n); endPkt(code);
  endtask

  task automatic command(input logic [4:0] op);
    cmdValid = 1'b1; cmdWord = {op, 11'd0}; tick(); cmdValid = 1'b0; cmdWord = 16'd0;
  endtask

  task automatic readBytes(input int n);
    for (int i = 0; i < n; i++) begin
      hostRead = 1'b1; tick();
    end
    hostRead = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    rstN = 1'b1;
    tick();
    // R12 reset state
    chk("R12 status", statusWord, 16'h8000);
    chk("R12 flags", {10'd0, rxComplete, rxReceiving, rxOverrun, statusOverrun, rxUnderrun, adapterFail}, 16'd0);

    // R1 R2 table of packets, each checked then discarded
    for (int v = 0; v < 7; v++) begin
      sendPkt(int'(VEC[v][10:0]), VEC[v][15:12]);
      chk("R2 status per code", statusWord, VEC[v][31:16]);
      chk("R10 complete", {15'd0, rxComplete}, 16'd1);
      command(5'd8);
      chk("R7 emptied", statusWord, 16'h8000);
    end

    // R1 R9 incomplete packet; R7 discard ignored on it
    startPkt();
    chk("R9 receiving", {15'd0, rxReceiving}, 16'd1);
    sendBytes(5);
    chk("R1 incomplete", statusWord, 16'h8005);
    chk("R10 not complete", {15'd0, rxComplete}, 16'd0);
    command(5'd8);
    chk("R7 discard incomplete", statusWord, 16'h8005);
    endPkt(4'd0);
    chk("R1 complete", statusWord, 16'h0005);
    chk("R9 receiving low", {15'd0, rxReceiving}, 16'd0);

    // R6 underrun
    readBytes(5);
    chk("R6 no underrun", {14'd0, rxUnderrun, adapterFail}, 16'd0);
    readBytes(1);
    chk("R6 underrun", {14'd0, rxUnderrun, adapterFail}, 16'd3);
    command(5'd8);
    chk("R6 sticky", {14'd0, rxUnderrun, adapterFail}, 16'd3);
    chk("R7 after discard", statusWord, 16'h8000);
    command(5'd5);
    chk("R8 clears underrun", {14'd0, rxUnderrun, adapterFail}, 16'd0);
    command(5'd8);
    chk("R7 empty discard", {statusWord[15:1], rxUnderrun}, 16'h8000);

    // R4 R11 queue full and ordering
    for (int i = 0; i < 8; i++) sendPkt(i + 1, 4'd0);
    chk("R4 status overrun", {15'd0, statusOverrun}, 16'd1);
    startPkt();
    chk("R4 start refused", {15'd0, rxReceiving}, 16'd0);
    sendBytes(3); endPkt(4'd0);
    for (int i = 0; i < 8; i++) begin
      chk("R11 order", statusWord, 16'(i + 1));
      command(5'd8);
      if (i == 0) chk("R4 overrun drops", {15'd0, statusOverrun}, 16'd0);
    end
    chk("R4 refused packet absent", statusWord, 16'h8000);

    // R3 oversize
    sendPkt(1520, 4'd0);
    chk("R3 oversize", statusWord, 16'h4DEA);
    command(5'd8);

    // R5 buffer overrun and hysteresis
    sendPkt(1514, 4'd0);
    startPkt(); sendBytes(534 + 3); endPkt(4'd0);
    chk("R5 overrun set", {15'd0, rxOverrun}, 16'd1);
    startPkt();
    chk("R5 start refused", {15'd0, rxReceiving}, 16'd0);
    chk("R5 top unchanged", statusWord, 16'h05EA);
    readBytes(3); tick();
    chk("R5 hysteresis holds", {15'd0, rxOverrun}, 16'd1);
    readBytes(1); tick();
    chk("R5 overrun clears", {15'd0, rxOverrun}, 16'd0);
    command(5'd8);
    chk("R5 truncated code", statusWord, 16'h4216);
    command(5'd8);
    chk("R5 emptied", statusWord, 16'h8000);

    // R8 abandon packet in progress
    startPkt(); sendBytes(3);
    command(5'd5);
    chk("R8 receiving cleared", {15'd0, rxReceiving}, 16'd0);
    chk("R8 queue empty", statusWord, 16'h8000);
    sendBytes(2); endPkt(4'd0);
    chk("R8 rest ignored", {statusWord[15:1], rxComplete}, 16'h8000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule